// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns an input clock into a slower clock whose average period is a fraction of input cycles. It uses two integer divide ratios, A and B. It runs them in a repeating frame made of C periods at ratio A and D periods at ratio B. One frame therefore spans A·C + B·D input cycles and delivers C + D output periods, and the long-run ratio is (A·C + B·D)/(C + D).

The order of the A and B periods within a frame comes from an error accumulator. The accumulator adds D once per output period. When the sum reaches C + D, that period uses ratio B and C + D is taken off the sum. This spreads the B periods as evenly as the frame allows.

The four settings may change at any time, but they are taken into the block only when a new frame starts. A one-cycle strobe marks each frame start. Both outputs are driven straight from flops.

Top module: `frac_clk_div`

## Requirements
- R1: Every output period is A or B input cycles long. A frame holds exactly C periods of length A and D periods of length B. When A equals B, all C + D periods have that length.
- R2: One frame lasts exactly P = A·C + B·D input cycles, counted from one `frame_o` pulse to the next.
- R3: One frame contains exactly Q = C + D output periods. A period starts on each rising edge of `clk_div_o`.
- R4: A period of length L is high for floor(L/2) input cycles and then low for the remaining L − floor(L/2) cycles.
- R5: A ratio setting below 2 is used as 2. When C and D are both 0, C is used as 1 and D as 0.
- R6: Period k of a frame (counting from 0) uses ratio B exactly when floor((k+1)·D/Q) > floor(k·D/Q). Otherwise it uses ratio A.
- R7: The inputs `ratio_a_i`, `ratio_b_i`, `slots_a_i` and `slots_b_i` are sampled only on the clock edge that starts a frame. A change inside a frame has no effect until the next frame.
- R8: `frame_o` is high for exactly one input cycle, which is the first cycle of each frame. In that cycle `clk_div_o` is also high.
- R9: A synchronous active-high `rst` drives `clk_div_o` and `frame_o` low and clears all internal state. The first clock edge with `rst` low starts a frame and its first period, so both outputs are high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_a_i | input | RATIO_W (8) | Divide ratio A |
| ratio_b_i | input | RATIO_W (8) | Divide ratio B |
| slots_a_i | input | SLOT_W (6) | Number of A periods per frame (C) |
| slots_b_i | input | SLOT_W (6) | Number of B periods per frame (D) |
| clk_div_o | output | 1 | Divided clock, registered |
| frame_o | output | 1 | One-cycle frame-start strobe |

## Verification
Some properties are checked on every cycle:
- the frame strobe lines up with a high output cycle and never lasts two cycles;
- reset release starts a frame on the next edge;
- each low run is equal to, or one cycle longer than, the high run before it;
- no period exceeds the largest ratio the inputs can encode.

Other properties depend on the settings and can only be shown by the bench scenarios. These are the exact frame length, the period count, the split between A and B periods, and the evenly spread order. The bench also covers clamping of out-of-range settings and settings changed part-way through a frame.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Width of each divide ratio input
    localparam int RATIO_W   = 8;
    // Width of each period-count input
    localparam int SLOT_W    = 6;
    // Derived widths: periods per frame, accumulator headroom
    localparam int QCNT_W    = SLOT_W + 1;
    localparam int ACC_W     = SLOT_W + 2;
    localparam int MIN_RATIO = 2;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [QCNT_W-1:0]  qcnt_t;
    typedef logic [ACC_W-1:0]   acc_t;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_e;

    typedef struct packed {
        ratio_t ra;
        ratio_t rb;
        slot_t  ca;
        slot_t  cb;
    } cfg_t;

    function automatic ratio_t clamp_ratio(ratio_t r);
        return (r < ratio_t'(MIN_RATIO)) ? ratio_t'(MIN_RATIO) : r;
    endfunction

    function automatic cfg_t clamp_cfg(cfg_t raw);
        cfg_t c;
        c    = raw;
        c.ra = clamp_ratio(raw.ra);
        c.rb = clamp_ratio(raw.rb);
        if (raw.ca == '0 && raw.cb == '0) begin
            c.ca = slot_t'(1);
        end
        return c;
    endfunction

    function automatic qcnt_t frame_periods(cfg_t c);
        return qcnt_t'(c.ca) + qcnt_t'(c.cb);
    endfunction

endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t raw_i,
    input  logic load_i,
    output cfg_t cur_o,
    output cfg_t next_o
);

    cfg_t held_q;
    cfg_t clamped;

    always_comb begin
        clamped = clamp_cfg(raw_i);
    end

    assign cur_o  = held_q;
    assign next_o = load_i ? clamped : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= clamped;
        end
    end

endmodule

// File: rtl/fdiv_sched.sv
module fdiv_sched
    import fdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   period_end_i,
    input  logic   first_i,
    input  cfg_t   cfg_cur_i,
    input  cfg_t   cfg_next_i,
    output logic   frame_end_o,
    output ratio_t len_o
);

    qcnt_t idx_q;
    acc_t  acc_q;
    qcnt_t q_cur;
    qcnt_t q_next;
    acc_t  base;
    acc_t  sum;
    acc_t  acc_nxt;
    sel_e  choice;

    assign q_cur       = frame_periods(cfg_cur_i);
    assign frame_end_o = first_i | (period_end_i & (idx_q == q_cur - qcnt_t'(1)));

    always_comb begin
        q_next = frame_periods(cfg_next_i);
        base   = frame_end_o ? '0 : acc_q;
        sum    = base + acc_t'(cfg_next_i.cb);
        if (sum >= acc_t'(q_next)) begin
            choice  = SEL_B;
            acc_nxt = sum - acc_t'(q_next);
        end else begin
            choice  = SEL_A;
            acc_nxt = sum;
        end
        len_o = (choice == SEL_B) ? cfg_next_i.rb : cfg_next_i.ra;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (period_end_i) begin
            acc_q <= acc_nxt;
            idx_q <= frame_end_o ? '0 : idx_q + qcnt_t'(1);
        end
    end

endmodule

// File: rtl/fdiv_period.sv
module fdiv_period
    import fdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t len_i,
    input  logic   frame_start_i,
    output logic   period_end_o,
    output logic   first_o,
    output logic   clk_div_o,
    output logic   frame_o
);

    ratio_t pos_q;
    ratio_t len_q;
    logic   run_q;
    logic   out_q;
    logic   frm_q;

    assign first_o      = !run_q;
    assign period_end_o = !run_q | (pos_q == len_q - ratio_t'(1));
    assign clk_div_o    = out_q;
    assign frame_o      = frm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            len_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b0;
            frm_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            frm_q <= frame_start_i;
            if (period_end_o) begin
                pos_q <= '0;
                len_q <= len_i;
                out_q <= 1'b1;
            end else begin
                pos_q <= pos_q + ratio_t'(1);
                out_q <= (pos_q + ratio_t'(1)) < (len_q >> 1);
            end
        end
    end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_a_i,
    input  logic [RATIO_W-1:0] ratio_b_i,
    input  logic [SLOT_W-1:0]  slots_a_i,
    input  logic [SLOT_W-1:0]  slots_b_i,
    output logic               clk_div_o,
    output logic               frame_o
);

    cfg_t   raw;
    cfg_t   cfg_cur;
    cfg_t   cfg_next;
    logic   period_end;
    logic   first;
    logic   frame_end;
    ratio_t len_next;

    assign raw = '{ra: ratio_a_i, rb: ratio_b_i, ca: slots_a_i, cb: slots_b_i};

    fdiv_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .load_i (frame_end),
        .cur_o  (cfg_cur),
        .next_o (cfg_next)
    );

    fdiv_sched u_sched (
        .clk          (clk),
        .rst          (rst),
        .period_end_i (period_end),
        .first_i      (first),
        .cfg_cur_i    (cfg_cur),
        .cfg_next_i   (cfg_next),
        .frame_end_o  (frame_end),
        .len_o        (len_next)
    );

    fdiv_period u_period (
        .clk           (clk),
        .rst           (rst),
        .len_i         (len_next),
        .frame_start_i (frame_end),
        .period_end_o  (period_end),
        .first_o       (first),
        .clk_div_o     (clk_div_o),
        .frame_o       (frame_o)
    );

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
    import fdiv_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic clk_div_o,
    input logic frame_o
);

    localparam int RUN_W = RATIO_W + 1;

    logic             prev_o;
    logic             seen_fall;
    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] lo_run;
    logic [RUN_W-1:0] since_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_o     <= 1'b0;
            seen_fall  <= 1'b0;
            hi_run     <= '0;
            lo_run     <= '0;
            since_rise <= '0;
        end else begin
            prev_o <= clk_div_o;
            if (clk_div_o) begin
                hi_run <= prev_o ? hi_run + RUN_W'(1) : RUN_W'(1);
            end else begin
                lo_run <= prev_o ? RUN_W'(1) : lo_run + RUN_W'(1);
                if (prev_o) begin
                    seen_fall <= 1'b1;
                end
            end
            since_rise <= (clk_div_o && !prev_o) ? RUN_W'(1) : since_rise + RUN_W'(1);
        end
    end

    // R8
    frame_high_chk: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> clk_div_o);

    // R8
    frame_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> !frame_o);

    // R9
    reset_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |=> (clk_div_o && frame_o));

    // R4
    duty_split_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_div_o && !prev_o && seen_fall) |->
            ((lo_run >= hi_run) && (lo_run <= hi_run + RUN_W'(1))));

    // R1
    period_bound_chk: assert property (@(posedge clk) disable iff (rst)
        since_rise < RUN_W'(2 ** RATIO_W));

endmodule

bind frac_clk_div fdiv_chk u_fdiv_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_div_o (clk_div_o),
    .frame_o   (frame_o)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
    import fdiv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int a;
        int b;
        int c;
        int d;
        int p;
        int q;
    } frame_exp_t;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    ratio_t ra_in = ratio_t'(3);
    ratio_t rb_in = ratio_t'(4);
    slot_t  ca_in = slot_t'(2);
    slot_t  cb_in = slot_t'(1);
    logic   div_o;
    logic   frm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [1:0]   wave_q[$];
    frame_exp_t frame_q[$];
    bit [1:0]   exp_now = 2'b00;
    bit         mdl_rst = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frac_clk_div i_frac_clk_div (
        .clk       (clk),
        .rst       (rst),
        .ratio_a_i (ra_in),
        .ratio_b_i (rb_in),
        .slots_a_i (ca_in),
        .slots_b_i (cb_in),
        .clk_div_o (div_o),
        .frame_o   (frm_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reference: build a whole frame from the inputs seen at its start edge
    task automatic build_frame();
        frame_exp_t e;
        e.a = (int'(ra_in) < 2) ? 2 : int'(ra_in);
        e.b = (int'(rb_in) < 2) ? 2 : int'(rb_in);
        e.c = int'(ca_in);
        e.d = int'(cb_in);
        if (e.c == 0 && e.d == 0) e.c = 1;
        e.q = e.c + e.d;
        e.p = e.a * e.c + e.b * e.d;
        for (int k = 0; k < e.q; k++) begin
            int len;
            bit use_b;
            use_b = ((k + 1) * e.d) / e.q > (k * e.d) / e.q;
            len = use_b ? e.b : e.a;
            for (int j = 0; j < len; j++) begin
                wave_q.push_back({bit'(j < len / 2), bit'(k == 0 && j == 0)});
            end
        end
        frame_q.push_back(e);
    endtask

    always @(posedge clk) begin
        mdl_rst = rst;
        if (rst) begin
            wave_q.delete();
            frame_q.delete();
            exp_now = 2'b00;
        end else begin
            if (wave_q.size() == 0) build_frame();
            exp_now = wave_q.pop_front();
        end
    end

    // Monitor: per-cycle compare and per-frame measurement
    bit prev_o = 0;
    bit in_frame = 0;
    int cyc = 0;
    int cur_len = 0;
    int n_a = 0;
    int n_b = 0;
    int n_bad = 0;
    int n_per = 0;

    always @(negedge clk) begin
        if (mdl_rst) begin
            chk({div_o, frm_o} == exp_now, "R9 outputs during reset",
                int'({div_o, frm_o}), int'(exp_now));
            in_frame = 0;
            prev_o = 0;
            cur_len = 0;
        end else begin
            bit rise;
            chk({div_o, frm_o} == exp_now, "R4 R6 R8 cycle waveform",
                int'({div_o, frm_o}), int'(exp_now));
            rise = div_o && !prev_o;
            if (rise && in_frame && frame_q.size() > 0) begin
                if (cur_len == frame_q[0].a) n_a++;
                else if (cur_len == frame_q[0].b) n_b++;
                else n_bad++;
                n_per++;
            end
            if (frm_o) begin
                if (in_frame && frame_q.size() > 0) begin
                    frame_exp_t e;
                    int ea;
                    int eb;
                    e = frame_q.pop_front();
                    ea = (e.a == e.b) ? e.c + e.d : e.c;
                    eb = (e.a == e.b) ? 0 : e.d;
                    chk(cyc == e.p, "R2 frame length", cyc, e.p);
                    chk(n_per == e.q, "R3 periods per frame", n_per, e.q);
                    chk(n_a == ea && n_bad == 0, "R1 A-period count", n_a, ea);
                    chk(n_b == eb && n_bad == 0, "R1 B-period count", n_b, eb);
                end
                in_frame = 1;
                cyc = 0;
                n_a = 0;
                n_b = 0;
                n_bad = 0;
                n_per = 0;
            end
            if (rise) cur_len = 0;
            cyc++;
            cur_len++;
            prev_o = div_o;
        end
    end

    task automatic set_cfg(input int a, input int b, input int c, input int d);
        ra_in = ratio_t'(a);
        rb_in = ratio_t'(b);
        ca_in = slot_t'(c);
        cb_in = slot_t'(d);
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!frm_o);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(div_o == 1'b0 && frm_o == 1'b0, "R9 reset state", int'({div_o, frm_o}), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(div_o == 1'b1 && frm_o == 1'b1, "R9 first period after release",
            int'({div_o, frm_o}), 3);
        repeat (60) @(posedge clk);

        // mixed ratios, B spread inside frame (R6)
        set_cfg(2, 3, 3, 5);
        repeat (100) @(posedge clk);
        set_cfg(7, 2, 4, 3);
        repeat (150) @(posedge clk);
        // only A periods, then only B periods
        set_cfg(4, 9, 5, 0);
        repeat (60) @(posedge clk);
        set_cfg(3, 6, 0, 4);
        repeat (60) @(posedge clk);

        // R5: clamped settings give a 2-cycle frame
        set_cfg(0, 1, 0, 0);
        wait_frame();
        wait_frame();
        for (int f = 0; f < 4; f++) begin
            n = 0;
            do begin @(negedge clk); n++; end while (!frm_o);
            chk(n == 2, "R5 clamped frame length", n, 2);
        end

        // R7: mid-frame change must not affect the running frame
        set_cfg(5, 3, 2, 1);
        wait_frame();
        wait_frame();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) set_cfg(2, 2, 1, 0);
        end while (!frm_o);
        chk(n == 13, "R7 frame kept old settings", n, 13);
        n = 0;
        do begin @(negedge clk); n++; end while (!frm_o);
        chk(n == 2, "R7 new settings at next frame", n, 2);

        // R9: reset in mid-run, then restart
        set_cfg(3, 5, 2, 3);
        repeat (17) @(posedge clk);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(div_o == 1'b0 && frm_o == 1'b0, "R9 mid-run reset", int'({div_o, frm_o}), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(div_o == 1'b1 && frm_o == 1'b1, "R9 restart after reset",
            int'({div_o, frm_o}), 3);
        repeat (80) @(posedge clk);

        done = 1;
        finish_run();
    end

endmodule